// File: doc/BRIEF.md
# Periodic and One-Shot Event Timer Channel

This block is a single comparator channel for a high-resolution event timer. It watches a free-running 64-bit main counter, which is supplied from outside, and flags an event when the counter equals the channel's comparator. In one-shot mode the comparator is only ever changed by software. Because the counter keeps running, the same comparator value fires again each time the counter comes back round to it after a wrap.

If the instance is built with periodic capability, the channel can also run periodically. It holds a hidden period register. On each match the comparator advances by that period, so a read of the comparator always gives the next match point. A write to a comparator half normally updates only the period. A self-clearing value-set bit in the configuration word makes the next half-write load the comparator directly as well. This lets software load a 64-bit comparator through two 32-bit writes.

Software reaches the channel through three 32-bit register slots: configuration, comparator low half and comparator high half. Each slot has its own write strobe and read strobe. A global enable gates every event. The interrupt output runs either in level mode, where it follows a sticky status bit, or in pulse mode, where it gives one clock per match.

Top module: `evt_timer_chan`

## Requirements
- R1: When the global enable is high and the counter equals the comparator on a clock edge, status (configuration bit 8) is set after that edge. The same value matches again at every later equality.
- R2: In one-shot mode (configuration bit 2 low) the comparator changes only through software writes. A match leaves it unchanged.
- R3: In periodic mode (bit 2 high) each match adds the period to the comparator. Reading the low or high slot returns the comparator, which is the next match point.
- R4: In periodic mode, a half-write made without value-set changes only that half of the period. The comparator reads back unchanged, and the new period is used at the next match.
- R5: Writing configuration bit 5 arms value-set. The next single half-write then loads both the comparator half and the period half, and value-set clears itself. Bit 5 always reads back as 0.
- R6: Configuration bit 4 selects the width and is 0 at reset. When it is 0, only counter bits 31:0 are compared and the reload adds modulo 2^32, leaving comparator bits 63:32 unchanged. When it is 1, all 64 bits are compared and the reload adds modulo 2^64.
- R7: Configuration bit 3 is read-only and reports the periodic capability. If the capability is absent, bit 2 reads 0 and the channel behaves as one-shot.
- R8: While the global enable is low, no match sets status, raises the interrupt or reloads the comparator.
- R9: In level mode (bit 1 low), the output equals status AND interrupt enable (bit 0) AND the global enable. Status stays set until a configuration write with bit 8 high clears it.
- R10: In pulse mode (bit 1 high) with the interrupt enabled, each match drives the output high for exactly the one clock after the match edge.
- R11: If a match coincides with a comparator half-write: a value-set load takes the written value and no reload happens that cycle. A period-only write lets the reload add the old period and stores the new one.
- R12: Reset values: configuration reads as the capability bit alone, the comparator is all ones, the period is zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_cfg | input | 1 | Write strobe, configuration slot |
| wr_lo | input | 1 | Write strobe, comparator low half |
| wr_hi | input | 1 | Write strobe, comparator high half |
| rd_cfg | input | 1 | Read strobe, configuration slot |
| rd_lo | input | 1 | Read strobe, comparator low half |
| rd_hi | input | 1 | Read strobe, comparator high half |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the strobed slot, zero when none |
| main_cnt | input | 64 | Main counter value |
| glb_en | input | 1 | Global enable for event generation |
| irq | output | 1 | Interrupt, level or pulse |

## Verification
A periodic reload and a software write to a comparator half can fall in the same clock. The bench provokes this by holding the counter equal to the comparator during the cycle that strobes a low-half write. It does this once without value-set armed and once with it armed. The bench then reads the comparator back and lets the counter reach the next match. This shows whether the old period was added and the new one kept, or whether the direct load won with no reload that cycle.

// File: rtl/evt_timer_chan.sv
module evt_timer_chan #(
  parameter bit          PERIODIC_CAP = 1'b1,
  parameter logic [63:0] CMP_RESET    = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cfg,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        rd_cfg,
  input  logic        rd_lo,
  input  logic        rd_hi,
  input  logic [31:0] wdata,
  output logic [31:0] rd_data,
  input  logic [63:0] main_cnt,
  input  logic        glb_en,
  output logic        irq
);
  localparam int HW = 32;

  logic        ien, pulse, per, wide, vset, sts, irq_p;
  logic [63:0] cmp, per_val, reload;
  logic        match, hit, load_lo, load_hi;
  logic [31:0] cfg_rd;

  assign match   = wide ? (main_cnt == cmp) : (main_cnt[HW-1:0] == cmp[HW-1:0]);
  assign hit     = glb_en & match;
  assign load_lo = wr_lo & (~per | vset);
  assign load_hi = wr_hi & (~per | vset);
  assign reload  = wide ? cmp + per_val
                        : {cmp[63:HW], cmp[HW-1:0] + per_val[HW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= 1'b0;
      pulse   <= 1'b0;
      per     <= 1'b0;
      wide    <= 1'b0;
      vset    <= 1'b0;
      sts     <= 1'b0;
      irq_p   <= 1'b0;
      cmp     <= CMP_RESET;
      per_val <= '0;
    end else begin
      irq_p <= hit & ien & pulse;
      if (hit) sts <= 1'b1;
      else if (wr_cfg && wdata[8]) sts <= 1'b0;
      if (wr_cfg) begin
        ien   <= wdata[0];
        pulse <= wdata[1];
        per   <= wdata[2] & PERIODIC_CAP;
        wide  <= wdata[4];
        vset  <= wdata[5];
      end else if (wr_lo || wr_hi) begin
        vset <= 1'b0;
      end
      if (wr_lo) per_val[HW-1:0] <= wdata;
      if (wr_hi) per_val[63:HW]  <= wdata;
      if (hit && per && !load_lo && !load_hi) cmp <= reload;
      if (load_lo) cmp[HW-1:0] <= wdata;
      if (load_hi) cmp[63:HW]  <= wdata;
    end
  end

  assign cfg_rd  = {23'b0, sts, 3'b0, wide, PERIODIC_CAP, per, pulse, ien};
  assign rd_data = rd_cfg ? cfg_rd : rd_lo ? cmp[HW-1:0] : rd_hi ? cmp[63:HW] : '0;
  assign irq     = pulse ? irq_p : (sts & ien & glb_en);
endmodule

module evt_timer_chan_chk #(
  parameter bit CAP = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_cfg,
  input logic        wr_lo,
  input logic        wr_hi,
  input logic        glb_en,
  input logic        irq,
  input logic        per,
  input logic        vset,
  input logic        sts,
  input logic        pulse,
  input logic        ien,
  input logic        wide,
  input logic        hit,
  input logic [63:0] cmp,
  input logic [63:0] per_val
);
  p_oneshot_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!per && !wr_lo && !wr_hi) |=> $stable(cmp));

  p_reload_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per && wide && !wr_lo && !wr_hi) |=> cmp == $past(cmp) + $past(per_val));

  p_reload_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per && !wide && !wr_lo && !wr_hi) |=>
      (cmp[31:0] == $past(cmp[31:0]) + $past(per_val[31:0])) && (cmp[63:32] == $past(cmp[63:32])));

  p_vset_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vset && !wr_cfg && (wr_lo || wr_hi)) |=> !vset);

  p_no_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    CAP || !per);

  p_gen_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !$rose(sts));

  p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ien && !pulse && !wr_cfg) |=> (irq || !glb_en));

  p_pulse_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && irq && !hit && !wr_cfg) |=> !irq);
endmodule

bind evt_timer_chan evt_timer_chan_chk #(.CAP(PERIODIC_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_lo(wr_lo), .wr_hi(wr_hi),
  .glb_en(glb_en), .irq(irq), .per(per), .vset(vset), .sts(sts), .pulse(pulse),
  .ien(ien), .wide(wide), .hit(hit), .cmp(cmp), .per_val(per_val)
);

// File: tb/sim_evt_timer_chan.sv
`timescale 1ns/1ps
module sim_evt_timer_chan;
  localparam logic [63:0] PARK = 64'h5555_5555_5555_5555;
  // fields: wide, expected status, comparator, counter
  localparam logic [129:0] VEC [6] = '{
    {1'b0, 1'b1, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0010},
    {1'b0, 1'b1, 64'h0000_0000_0000_0010, 64'hFFFF_0000_0000_0010},
    {1'b1, 1'b0, 64'h0000_0000_0000_0010, 64'hFFFF_0000_0000_0010},
    {1'b1, 1'b1, 64'h0000_0001_0000_0010, 64'h0000_0001_0000_0010},
    {1'b0, 1'b0, 64'h0000_0000_0000_0020, 64'h0000_0000_0000_0021},
    {1'b1, 1'b1, 64'hABCD_0000_1234_5678, 64'hABCD_0000_1234_5678}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_cfg = 0, wr_lo = 0, wr_hi = 0, rd_cfg = 0, rd_lo = 0, rd_hi = 0, glb_en = 0;
  logic [31:0] wdata = '0;
  logic [63:0] main_cnt = PARK;
  logic [31:0] rd0, rd1;
  logic irq0, irq1;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  evt_timer_chan u0 (.clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_cfg(rd_cfg), .rd_lo(rd_lo), .rd_hi(rd_hi), .wdata(wdata), .rd_data(rd0),
    .main_cnt(main_cnt), .glb_en(glb_en), .irq(irq0));
  evt_timer_chan #(.PERIODIC_CAP(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .rd_cfg(rd_cfg), .rd_lo(rd_lo), .rd_hi(rd_hi), .wdata(wdata), .rd_data(rd1),
    .main_cnt(main_cnt), .glb_en(glb_en), .irq(irq1));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [31:0] d);
    wr_cfg = 1; wdata = d; @(negedge clk); wr_cfg = 0;
  endtask
  task automatic wlo(input logic [31:0] d);
    wr_lo = 1; wdata = d; @(negedge clk); wr_lo = 0;
  endtask
  task automatic whi(input logic [31:0] d);
    wr_hi = 1; wdata = d; @(negedge clk); wr_hi = 0;
  endtask
  task automatic rd(input int slot, output logic [31:0] a, output logic [31:0] b);
    rd_cfg = (slot == 0); rd_lo = (slot == 1); rd_hi = (slot == 2);
    #0.5; a = rd0; b = rd1;
    rd_cfg = 0; rd_lo = 0; rd_hi = 0;
  endtask
  task automatic match_once(input logic [63:0] c);
    main_cnt = c; glb_en = 1; @(negedge clk); glb_en = 0; main_cnt = PARK;
  endtask

  logic [31:0] a, b;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    rd(0, a, b); chk("R12 cfg u0", a, 32'h8); chk("R12 cfg u1", b, 32'h0);
    rd(1, a, b); chk("R12 cmp lo", a, 32'hFFFF_FFFF);
    chk("R12 irq", irq0, 0);

    // R1 R6 table of one-shot matches
    foreach (VEC[i]) begin
      wcfg({23'b0, 1'b1, 3'b0, VEC[i][129], 4'b0});
      wlo(VEC[i][95:64]); whi(VEC[i][127:96]);
      match_once(VEC[i][63:0]);
      rd(0, a, b);
      chk($sformatf("R1/R6 vector %0d status", i), a[8], VEC[i][128]);
    end

    // R2 comparator unchanged after one-shot match; R1 repeat equality
    rd(1, a, b); chk("R2 cmp lo kept", a, 32'h1234_5678);
    rd(2, a, b); chk("R2 cmp hi kept", a, 32'hABCD_0000);
    wcfg(32'h110);
    match_once(64'hABCD_0000_1234_5678);
    rd(0, a, b); chk("R1 second match status", a[8], 1);

    // R9 level output
    wcfg(32'h111);
    main_cnt = 64'hABCD_0000_1234_5678; glb_en = 1; @(negedge clk); main_cnt = PARK;
    chk("R9 level high", irq0, 1);
    @(negedge clk); chk("R9 level held", irq0, 1);
    wcfg(32'h010); chk("R9 enable low masks", irq0, 0);
    rd(0, a, b); chk("R9 status stays", a[8], 1);
    wcfg(32'h111); chk("R9 cleared by write one", irq0, 0);
    rd(0, a, b); chk("R9 status cleared", a[8], 0);
    glb_en = 0;

    // R10 pulse output
    wcfg(32'h113);
    main_cnt = 64'hABCD_0000_1234_5678; glb_en = 1; @(negedge clk); main_cnt = PARK;
    chk("R10 pulse high", irq0, 1);
    @(negedge clk); chk("R10 pulse one clock", irq0, 0);
    rd(0, a, b); chk("R10 status set", a[8], 1);
    glb_en = 0;

    // R8 global enable off
    wcfg(32'h111);
    main_cnt = 64'hABCD_0000_1234_5678; @(negedge clk); @(negedge clk); main_cnt = PARK;
    chk("R8 no irq", irq0, 0);
    rd(0, a, b); chk("R8 no status", a[8], 0);

    // R3 periodic reload, R7 capability
    wcfg(32'h124); wlo(32'd100); wcfg(32'h24); whi(32'd0);
    rd(0, a, b); chk("R5 cfg u0 value-set reads 0", a, 32'h0C); chk("R7 cfg u1", b, 32'h0);
    main_cnt = 64'd100; @(negedge clk); main_cnt = PARK;
    rd(1, a, b); chk("R8 no reload while off", a, 32'd100);
    match_once(64'd100);
    rd(1, a, b); chk("R3 next point", a, 32'd200); chk("R7 u1 one-shot holds", b, 32'd100);
    match_once(64'd200);
    rd(1, a, b); chk("R3 second reload", a, 32'd300);

    // R4 period-only write
    wlo(32'd50);
    rd(1, a, b); chk("R4 cmp unchanged", a, 32'd300);
    match_once(64'd300);
    rd(1, a, b); chk("R4 new period used", a, 32'd350);

    // R5 value-set needed per half
    wcfg(32'h24); wlo(32'h1000); whi(32'h7);
    rd(1, a, b); chk("R5 low loaded", a, 32'h1000);
    rd(2, a, b); chk("R5 high not loaded without bit", a, 32'h0);
    wcfg(32'h24); whi(32'h7);
    rd(2, a, b); chk("R5 high loaded", a, 32'h7);

    // R6 wrap in 32-bit and 64-bit periodic
    wcfg(32'h24); wlo(32'hFFFF_FFF0); wlo(32'h20); wcfg(32'h24); whi(32'h0);
    match_once(64'h1234_5678_FFFF_FFF0);
    rd(1, a, b); chk("R6 narrow wrap lo", a, 32'h10);
    rd(2, a, b); chk("R6 narrow hi kept", a, 32'h0);
    wcfg(32'h34); wlo(32'hFFFF_FFF0); wlo(32'h20); wcfg(32'h34); whi(32'h0);
    match_once(64'h0000_0000_FFFF_FFF0);
    rd(1, a, b); chk("R6 wide carry lo", a, 32'h10);
    rd(2, a, b); chk("R6 wide carry hi", a, 32'h1);

    // R11 same-cycle write and match
    wcfg(32'h24); wlo(32'h400); wlo(32'h100); wcfg(32'h24); whi(32'h0);
    main_cnt = 64'h400; glb_en = 1; wr_lo = 1; wdata = 32'h80;
    @(negedge clk); wr_lo = 0; glb_en = 0; main_cnt = PARK;
    rd(1, a, b); chk("R11 old period added", a, 32'h500);
    match_once(64'h500);
    rd(1, a, b); chk("R11 new period kept", a, 32'h580);
    wcfg(32'h24);
    main_cnt = 64'h580; glb_en = 1; wr_lo = 1; wdata = 32'h900;
    @(negedge clk); wr_lo = 0; glb_en = 0; main_cnt = PARK;
    rd(1, a, b); chk("R11 direct load wins", a, 32'h900);
    match_once(64'h900);
    rd(1, a, b); chk("R11 loaded period used", a, 32'h1200);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule